// File: doc/BRIEF.md
# Framed DDR serial sample transmitter

This block turns one parallel converter sample per frame into a bit-serial stream on a single data lane. It runs on a fast clock and sends one bit in every clock period, which is called a bit slot here. Alongside the data it drives two timing outputs. The first is a data clock whose edges fall in the middle of each bit slot, so a receiver can capture on both its rising and its falling edge. The second is a frame clock that marks the start of every word.

A frame holds 14 bit slots by default, and the data clock completes one period every two slots. When short-word mode is selected, only the 12 most significant sample bits are sent. In that mode the frame, and the frame clock with it, shrinks to 12 slots. The bit order can be changed from most-significant-first to least-significant-first.

The sample and both mode controls are captured only when a frame starts. A change made part-way through a word therefore takes effect at the next frame.

Top module: `ddr_frame_tx`

## Requirements
- R1: Reset is active-low and sampled at the rising clock edge. While it is held, ser_data and fco are low from the next rising edge, and dco is low from the next falling edge.
- R2: The first rising edge with rst_n high starts a frame at slot 0. Frames follow each other with no gap. A frame lasts 14 slots when short_word=0 and 12 slots when short_word=1.
- R3: With short_word=0 and lsb_first=0, slot k (counted from 0) carries sample_in[13-k].
- R4: dco rises at the middle (falling clock edge) of every even slot and falls at the middle of every odd slot, giving one dco period per two bit slots.
- R5: sample_in, short_word and lsb_first are sampled only at the rising edge that begins slot 0. Changing them during slots 1 to N-1 has no effect on the frame in progress.
- R6: fco is high during slots 0 to N/2-1 of each frame and low for the remaining slots. Its rising edge coincides with the first bit of the word.
- R7: With short_word=0 and lsb_first=1, slot k carries sample_in[k].
- R8: With short_word=1, the sent word is sample_in[13:2]. Slot k carries sample_in[13-k] when lsb_first=0 and sample_in[2+k] when lsb_first=1.
- R9: Asserting reset in the middle of a frame abandons that frame. After release, a fresh frame starts at slot 0 on the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit slot per period |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | 14 | Parallel sample, captured at frame start |
| short_word | input | 1 | 1 selects 12-bit words |
| lsb_first | input | 1 | 1 sends the least significant bit first |
| ser_data | output | 1 | Serial data lane |
| dco | output | 1 | Data clock, edges mid-bit |
| fco | output | 1 | Frame clock, high for the first half of the word |

## Verification
The demanding cycle is the one where the last slot of a word coincides with the load of the next word. In that cycle the bench changes the word length, the bit order and the sample together. It then checks that the new frame starts at slot 0 with the new length, the new half-frame fco width and the new first bit, and that the dco phase runs on without a break. The bench also changes all three inputs in the middle of a frame and checks that every remaining bit still matches the word captured at slot 0. A mid-frame reset is checked the same way: the frame must stop, and the next frame must start cleanly.

// File: rtl/sertx_pkg.sv
// Shared types for the framed serial transmitter.
package sertx_pkg;
    // Per-frame mode, captured at each frame start.
    typedef struct packed {
        logic short_word;   // 1: send the reduced-width word
        logic lsb_first;    // 1: least significant bit goes first
    } sertx_mode_t;
endpackage

// File: rtl/sertx_frame_timer.sv
// Frame timer: counts the bit slots of each frame, holds the mode that was
// captured at the frame start, and drives the frame clock.
// Assumes SHORT_W <= SAMPLE_W and that both widths are even.
module sertx_frame_timer
    import sertx_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int SHORT_W  = 12,
    parameter int SLOT_W   = $clog2(SAMPLE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sertx_mode_t       mode_in,
    output logic              active,
    output logic              frame_start,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] nxt_slot,
    output sertx_mode_t       nxt_mode,
    output logic              fco
);
    localparam logic [SLOT_W-1:0] FULL_LAST  = SLOT_W'(SAMPLE_W - 1);
    localparam logic [SLOT_W-1:0] SHORT_LAST = SLOT_W'(SHORT_W - 1);
    localparam logic [SLOT_W-1:0] FULL_HALF  = SLOT_W'(SAMPLE_W / 2);
    localparam logic [SLOT_W-1:0] SHORT_HALF = SLOT_W'(SHORT_W / 2);

    sertx_mode_t       mode_q;
    logic [SLOT_W-1:0] last_slot;
    logic [SLOT_W-1:0] half_slots;

    // Decide the next slot and whether a new frame begins.
    always_comb begin
        last_slot   = mode_q.short_word ? SHORT_LAST : FULL_LAST;
        frame_start = !active || (slot == last_slot);
        nxt_slot    = frame_start ? '0 : slot + 1'b1;
        nxt_mode    = frame_start ? mode_in : mode_q;
        half_slots  = nxt_mode.short_word ? SHORT_HALF : FULL_HALF;
    end

    // Advance the slot counter, hold the mode and drive the frame clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            slot   <= '0;
            mode_q <= '0;
            fco    <= 1'b0;
        end else begin
            active <= 1'b1;
            slot   <= nxt_slot;
            mode_q <= nxt_mode;
            fco    <= (nxt_slot < half_slots);
        end
    end

    // R2: the slot counter wraps to zero right after the last slot.
    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (active && slot == last_slot) |=> (slot == '0));

    // R5: the captured mode does not move inside a frame.
    a_r5_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != '0) |-> $stable(mode_q));

    // R6: the frame clock rises only with the first slot of a word.
    a_r6_fco_rise_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fco) |-> (slot == '0));
endmodule

// File: rtl/sertx_bit_select.sv
// Bit selector: holds the word captured at frame start and registers the
// bit that belongs to the upcoming slot onto the serial lane.
// Assumes nxt_slot stays below the active word length.
module sertx_bit_select
    import sertx_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int SHORT_W  = 12,
    parameter int SLOT_W   = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [SLOT_W-1:0]   nxt_slot,
    input  sertx_mode_t         nxt_mode,
    output logic                ser_data
);
    localparam logic [SLOT_W-1:0] TOP_IDX    = SLOT_W'(SAMPLE_W - 1);
    localparam logic [SLOT_W-1:0] SHORT_BASE = SLOT_W'(SAMPLE_W - SHORT_W);

    logic [SAMPLE_W-1:0] word_q;
    logic [SAMPLE_W-1:0] src;
    logic [SLOT_W-1:0]   base;
    logic [SLOT_W-1:0]   idx;

    // Pick the source word and the bit position for the next slot.
    always_comb begin
        src  = load ? sample_in : word_q;
        base = nxt_mode.short_word ? SHORT_BASE : '0;
        idx  = nxt_mode.lsb_first ? (base + nxt_slot) : (TOP_IDX - nxt_slot);
    end

    // Capture the word at frame start and launch the selected bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            ser_data <= 1'b0;
        end else begin
            if (load) begin
                word_q <= sample_in;
            end
            ser_data <= src[idx];
        end
    end
endmodule

// File: rtl/sertx_dco_gen.sv
// Data clock generator: launched from the falling clock edge so that each
// dco transition lands in the middle of a bit slot. High in even slots.
// Assumes the frame length is even, so the phase runs on across frames.
module sertx_dco_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic slot_odd,
    output logic dco
);
    // Mid-slot update: go high in even slots, low in odd slots, low when idle.
    always_ff @(negedge clk) begin
        dco <= active & ~slot_odd;
    end

    // R4: seen at consecutive rising edges of a running link, dco alternates.
    a_r4_dco_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> (dco != $past(dco)));
endmodule

// File: rtl/ddr_frame_tx.sv
// Top level of the framed DDR serial transmitter. One bit slot per clock.
// The sample is captured at each frame start; the data clock toggles mid-slot
// and the frame clock spans the first half of every word.
module ddr_frame_tx
    import sertx_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    parameter int SHORT_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                short_word,
    input  logic                lsb_first,
    output logic                ser_data,
    output logic                dco,
    output logic                fco
);
    localparam int SLOT_W = $clog2(SAMPLE_W);

    sertx_mode_t       mode_in;
    sertx_mode_t       nxt_mode;
    logic              active;
    logic              frame_start;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] nxt_slot;

    // Gather the mode pins into one field.
    always_comb begin
        mode_in.short_word = short_word;
        mode_in.lsb_first  = lsb_first;
    end

    sertx_frame_timer #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W), .SLOT_W(SLOT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .active(active),
        .frame_start(frame_start), .slot(slot), .nxt_slot(nxt_slot),
        .nxt_mode(nxt_mode), .fco(fco)
    );

    sertx_bit_select #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W), .SLOT_W(SLOT_W)) u_bits (
        .clk(clk), .rst_n(rst_n), .load(frame_start), .sample_in(sample_in),
        .nxt_slot(nxt_slot), .nxt_mode(nxt_mode), .ser_data(ser_data)
    );

    sertx_dco_gen u_dco (
        .clk(clk), .rst_n(rst_n), .active(active), .slot_odd(slot[0]), .dco(dco)
    );
endmodule

// File: tb/ddr_frame_tx_test.sv
// Directed bench for ddr_frame_tx: one task per scenario, each checking itself.
module ddr_frame_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] sample_in = '0;
    logic        short_word = 1'b0;
    logic        lsb_first = 1'b0;
    logic        ser_data, dco, fco;
    int          n_checks = 0;
    int          n_fail = 0;

    ddr_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .short_word(short_word),
        .lsb_first(lsb_first), .ser_data(ser_data), .dco(dco), .fco(fco)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_bit(input logic [13:0] s, input bit sh, input bit lsb, input int k);
        if (!sh) return lsb ? s[k] : s[13-k];
        return lsb ? s[2+k] : s[13-k];
    endfunction

    // One frame: inputs applied before its first edge; optional mid-frame disturbance (R5).
    task automatic run_frame(input logic [13:0] s, input bit sh, input bit lsb,
                             input bit disturb, input string tag);
        int n;
        n = sh ? 12 : 14;
        sample_in = s; short_word = sh; lsb_first = lsb;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2;
            check(ser_data == exp_bit(s, sh, lsb, k), tag, ser_data, exp_bit(s, sh, lsb, k));
            check(fco == (k < n/2), "R6/R2 fco", fco, (k < n/2));
            #4;
            check(dco == (k % 2 == 0), "R4 dco", dco, (k % 2 == 0));
            if (disturb && k == 3) begin
                sample_in = ~s; short_word = ~sh; lsb_first = ~lsb;
            end
        end
    endtask

    // Reset while a frame runs: outputs drop, then a new frame starts (R1, R9).
    task automatic reset_mid_frame();
        sample_in = 14'h1B3D; short_word = 1'b0; lsb_first = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk); #6;
        end
        rst_n = 1'b0;
        @(posedge clk); #2;
        check(ser_data == 1'b0, "R1 data in reset", ser_data, 0);
        check(fco == 1'b0, "R1 fco in reset", fco, 0);
        #4;
        check(dco == 1'b0, "R1 dco in reset", dco, 0);
        @(posedge clk); #6;
        rst_n = 1'b1;
        run_frame(14'h2C71, 1'b0, 1'b0, 1'b0, "R9 restart");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(ser_data == 1'b0, "R1 data reset", ser_data, 0);
        check(fco == 1'b0, "R1 fco reset", fco, 0);
        #4;
        check(dco == 1'b0, "R1 dco reset", dco, 0);
        sample_in = 14'h2A5C;
        rst_n = 1'b1;
        run_frame(14'h2A5C, 1'b0, 1'b0, 1'b0, "R3 msb14");
        run_frame(14'h1235, 1'b0, 1'b1, 1'b0, "R7 lsb14");
        run_frame(14'h3C96, 1'b1, 1'b0, 1'b0, "R8 msb12");
        run_frame(14'h0E6B, 1'b1, 1'b1, 1'b0, "R8 lsb12");
        run_frame(14'h3FFF, 1'b0, 1'b0, 1'b0, "R2 switch to 14");
        run_frame(14'h0001, 1'b1, 1'b0, 1'b0, "R2 switch to 12");
        run_frame(14'h2B4D, 1'b0, 1'b1, 1'b1, "R5 held 14");
        run_frame(14'h1A5F, 1'b1, 1'b0, 1'b1, "R5 held 12");
        reset_mid_frame();
        run_frame(14'h0FF3, 1'b1, 1'b1, 1'b0, "R8 after restart");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule